// File: doc/BRIEF.md
# Bulk-in multi-frame deframer

The block takes the byte stream of one received bulk transfer, in which several Ethernet frames are packed back to back, and splits it into separate frames on an AXI4-Stream output. An input marker flags the final byte of the transfer. Every frame in the transfer starts with a four-byte header, sent least significant byte first. The header holds the frame length in its low bits and the bitwise complement of that length in its upper half. The length is followed by the payload, and odd-length payloads carry one pad byte so that the next header starts on an even offset.

The block checks each header and compares the length with a run-time maximum (normally 1518: an MTU of 1500 plus 18 bytes). It forwards exactly the payload bytes, with tlast on the final one, and drops pad bytes. When a check fails it raises a one-cycle error pulse on one of three sideband outputs: header, length or transfer. It then drops the rest of the transfer. Backpressure on the output stalls intake while payload is flowing, and no byte is lost.

Top module: `usb_rx_deframer`

## Requirements
- R1: A header is four bytes, least significant byte first, forming word W. The frame length is W[10:0]. W[15:11] and W[31:27] are ignored.
- R2: If W[26:16] is not the bitwise inverse of W[10:0], err_hdr_o pulses and every further byte up to and including the last-byte marker is dropped with no output.
- R3: If the length exceeds max_len_i, err_len_o pulses and the rest of the transfer is dropped. A length equal to max_len_i is accepted.
- R4: A valid header with length L (1..max) produces exactly L output beats carrying the payload bytes in order, with m_tlast_o set only on the L-th beat. L = 0 produces no beat, and the next byte starts a new header.
- R5: After an odd-length payload, the next byte is a pad byte and is dropped. The byte after the pad starts a new header. After an even-length payload, the next byte starts a header directly.
- R6: A transfer ends cleanly only when the marker falls on the final payload byte of an even-length frame or on a pad byte. If the marker falls on any header byte (including the fourth) or on the final byte of an odd-length frame, err_xfer_o pulses.
- R7: If the marker arrives in mid-payload before the L-th byte, that byte is still forwarded with m_tlast_o set, err_len_o pulses, and the next byte starts a new header.
- R8: While the output beat is stalled by m_tready_i, in_ready_o is low during payload and the beat holds steady, so no byte is lost. Header, pad and dropped bytes are accepted whatever m_tready_i is.
- R9: Each error output is high for exactly one cycle, the cycle after the clock edge that accepted the offending byte. At most one error output is high at a time.
- R10: During and right after reset, m_tvalid_o and all error outputs are 0, in_ready_o is 1, and the block expects a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| max_len_i | input | LEN_W (11) | Largest accepted frame length |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of the transfer |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tready_i | input | 1 | Output beat taken |
| m_tdata_o | output | 8 | Payload byte |
| m_tlast_o | output | 1 | Final byte of the frame |
| err_hdr_o | output | 1 | Length/complement mismatch pulse |
| err_len_o | output | 1 | Oversize or truncated frame pulse |
| err_xfer_o | output | 1 | Transfer end misaligned pulse |

## Verification
A sweep of every single-frame length from 0 to past the maximum (with a trailing second frame) separates correct payload counting, pad skipping for odd lengths and the off-by-one at the maximum. Three families of damaged transfers each map to exactly one error output: one-bit complement corruption, truncation at every payload position, and a missing pad or trailing short header. Random multi-frame packs with random gaps and random tready, plus a long full-size frame at the 1518 setting, show that no byte is lost under backpressure. A directed stall shows intake stopping in mid-payload while header bytes are still taken.

// File: rtl/usb_deframer_pkg.sv
`timescale 1ns/1ps
package usb_deframer_pkg;
  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_PAD, ST_DROP} dfr_state_e;
  localparam int unsigned HDR_BYTES = 4;
endpackage

// File: rtl/usb_deframer_hdr.sv
`timescale 1ns/1ps
// Captures header bytes 0..2; byte 3 is checked as it arrives.
module usb_deframer_hdr #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [1:0]       idx_i,
  input  logic [7:0]       byte_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic [LEN_W-1:0] len_o,
  output logic             pair_ok_o,
  output logic             fits_o
);
  localparam int unsigned HI_W = LEN_W - 8;

  logic [7:0]      len_lo_q, chk_lo_q;
  logic [HI_W-1:0] len_hi_q;
  logic [LEN_W-1:0] chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_lo_q <= '0;
      len_hi_q <= '0;
      chk_lo_q <= '0;
    end else if (cap_i) begin
      case (idx_i)
        2'd0:    len_lo_q <= byte_i;
        2'd1:    len_hi_q <= byte_i[HI_W-1:0];
        2'd2:    chk_lo_q <= byte_i;
        default: ;
      endcase
    end
  end

  assign len_o     = {len_hi_q, len_lo_q};
  assign chk       = {byte_i[HI_W-1:0], chk_lo_q};
  assign pair_ok_o = &(chk ^ len_o);
  assign fits_o    = len_o <= max_len_i;
endmodule

// File: rtl/usb_deframer_obuf.sv
`timescale 1ns/1ps
// One-entry output register with backpressure.
module usb_deframer_obuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r8_push_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> free_o);
  a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
endmodule

// File: rtl/usb_rx_deframer.sv
`timescale 1ns/1ps
module usb_rx_deframer
  import usb_deframer_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             m_tvalid_o,
  input  logic             m_tready_i,
  output logic [7:0]       m_tdata_o,
  output logic             m_tlast_o,
  output logic             err_hdr_o,
  output logic             err_len_o,
  output logic             err_xfer_o
);
  localparam logic [1:0]       LAST_IDX = 2'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  dfr_state_e       state_q, state_d;
  logic [1:0]       idx_q;
  logic [LEN_W-1:0] rem_q, hdr_len;
  logic             odd_q, pair_ok, fits, slot_free;
  logic             acc, hdr_done, push, push_last;
  logic             e_hdr, e_len, e_xfer;

  assign in_ready_o = (state_q == ST_PAY) ? slot_free : 1'b1;
  assign acc        = in_valid_i && in_ready_o;
  assign hdr_done   = acc && (state_q == ST_HDR) && (idx_q == LAST_IDX) && !in_last_i;

  usb_deframer_hdr #(.LEN_W(LEN_W)) u_hdr (
    .clk_i, .rst_ni,
    .cap_i     (acc && (state_q == ST_HDR)),
    .idx_i     (idx_q),
    .byte_i    (in_data_i),
    .max_len_i (max_len_i),
    .len_o     (hdr_len),
    .pair_ok_o (pair_ok),
    .fits_o    (fits)
  );

  usb_deframer_obuf #(.DATA_W(8)) u_obuf (
    .clk_i, .rst_ni,
    .push_i  (push),
    .data_i  (in_data_i),
    .last_i  (push_last),
    .ready_i (m_tready_i),
    .valid_o (m_tvalid_o),
    .data_o  (m_tdata_o),
    .last_o  (m_tlast_o),
    .free_o  (slot_free)
  );

  always_comb begin
    state_d   = state_q;
    push      = 1'b0;
    push_last = 1'b0;
    e_hdr     = 1'b0;
    e_len     = 1'b0;
    e_xfer    = 1'b0;
    unique case (state_q)
      ST_HDR: if (acc) begin
        if (in_last_i) e_xfer = 1'b1;             // too few bytes left for a header
        else if (idx_q == LAST_IDX) begin
          if (!pair_ok) begin
            e_hdr = 1'b1; state_d = ST_DROP;
          end else if (!fits) begin
            e_len = 1'b1; state_d = ST_DROP;
          end else if (hdr_len != '0) begin
            state_d = ST_PAY;
          end
        end
      end
      ST_PAY: if (acc) begin
        push      = 1'b1;
        push_last = (rem_q == ONE) || in_last_i;
        if (rem_q != ONE) begin
          if (in_last_i) begin
            e_len = 1'b1; state_d = ST_HDR;       // truncated payload
          end
        end else if (!odd_q) begin
          state_d = ST_HDR;
        end else if (in_last_i) begin
          e_xfer = 1'b1; state_d = ST_HDR;        // pad missing
        end else begin
          state_d = ST_PAD;
        end
      end
      ST_PAD:  if (acc) state_d = ST_HDR;
      ST_DROP: if (acc && in_last_i) state_d = ST_HDR;
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HDR;
      idx_q      <= '0;
      rem_q      <= '0;
      odd_q      <= 1'b0;
      err_hdr_o  <= 1'b0;
      err_len_o  <= 1'b0;
      err_xfer_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_hdr_o  <= e_hdr;
      err_len_o  <= e_len;
      err_xfer_o <= e_xfer;
      if (acc && (state_q == ST_HDR))
        idx_q <= (in_last_i || idx_q == LAST_IDX) ? 2'd0 : idx_q + 2'd1;
      if (hdr_done) begin
        rem_q <= hdr_len;
        odd_q <= hdr_len[0];
      end else if (push) begin
        rem_q <= rem_q - ONE;
      end
    end
  end

  a_r9_single_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_hdr_o, err_len_o, err_xfer_o}));
  a_r8_stall_only_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (state_q == ST_PAY && m_tvalid_o));
  a_r4_payload_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY) |-> (rem_q != '0));
  a_r2_hdr_err_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hdr_o |-> (state_q == ST_DROP));
  a_r6_xfer_err_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_xfer_o |-> (state_q == ST_HDR && idx_q == 2'd0));
endmodule

// File: tb/tb_usb_rx_deframer.sv
`timescale 1ns/1ps
module tb_usb_rx_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] max_len = 11'd20;
  logic        in_valid = 1'b0, in_last = 1'b0, m_tready = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_ready, m_tvalid, m_tlast, e_hdr, e_len, e_xfer;
  logic [7:0]  m_tdata;

  always #5 clk = ~clk;

  usb_rx_deframer dut (
    .clk_i(clk), .rst_ni(rst_n), .max_len_i(max_len),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .m_tvalid_o(m_tvalid), .m_tready_i(m_tready), .m_tdata_o(m_tdata), .m_tlast_o(m_tlast),
    .err_hdr_o(e_hdr), .err_len_o(e_len), .err_xfer_o(e_xfer)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  logic [7:0] xb[$];
  logic [8:0] exp_q[$], got_q[$];
  int eh, el, ex, ch, cl, cx;
  bit fire_q = 0, hold = 0, bp = 0, gaps = 0;

  always @(posedge clk) fire_q <= in_valid && in_ready;
  always @(posedge clk) if (m_tvalid && m_tready) got_q.push_back({m_tlast, m_tdata});
  always @(negedge clk) m_tready = hold ? 1'b0 : (bp ? 1'($urandom_range(0, 1)) : 1'b1);
  always @(negedge clk) if (rst_n) begin
    ch += int'(e_hdr); cl += int'(e_len); cx += int'(e_xfer);
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nvec++; nfail++;
      $display("FAIL R9 watchdog: cycles=%0d expected < %0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pay(int len, int i);
    return 8'((len * 7 + i * 13 + 5) & 255);
  endfunction

  task automatic put_hdr(int len, bit bad, bit junk);
    logic [31:0] w;
    logic [10:0] c;
    c = ~11'(len);
    if (bad) c = c ^ 11'(1 << (len % 11));
    w = {5'b0, c, 5'b0, 11'(len)};
    if (junk) w = w | 32'hF800_F800;
    for (int b = 0; b < 4; b++) xb.push_back(w[8*b +: 8]);
  endtask

  task automatic put_frame(int len, bit pad);
    put_hdr(len, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) xb.push_back(pay(len, i));
    if (pad && (len % 2 == 1)) xb.push_back(8'hA5);
  endtask

  // Reference: offset walk over the whole transfer
  function automatic void model();
    int n = xb.size();
    int off = 0;
    logic [31:0] w;
    logic [10:0] len, c;
    exp_q.delete(); eh = 0; el = 0; ex = 0;
    while (1) begin
      if (n - off <= 4) begin if (off != n) ex++; break; end
      w = {xb[off+3], xb[off+2], xb[off+1], xb[off]};
      len = w[10:0]; c = w[26:16];
      if ((~c) != len) begin eh++; break; end
      if (len > max_len) begin el++; break; end
      off += 4;
      if (off + int'(len) > n) begin
        for (int i = off; i < n; i++) exp_q.push_back({i == n - 1, xb[i]});
        el++; break;
      end
      for (int i = 0; i < int'(len); i++) exp_q.push_back({i == int'(len) - 1, xb[off + i]});
      off += int'(len);
      if (len[0]) begin
        if (off == n) begin ex++; break; end
        off++;
      end
    end
  endfunction

  task automatic send();
    foreach (xb[i]) begin
      @(negedge clk);
      while (gaps && $urandom_range(0, 3) == 0) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = xb[i]; in_last = (i == xb.size() - 1);
      do begin @(posedge clk); #1; end while (!fire_q);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic prep();
    model();
    got_q.delete(); ch = 0; cl = 0; cx = 0;
  endtask

  task automatic finish_x(string tag);
    int bad_i = -1;
    repeat (4) @(negedge clk);
    while (m_tvalid) @(negedge clk);
    repeat (2) @(negedge clk);
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) if (bad_i < 0 && got_q[i] !== exp_q[i]) bad_i = i;
    if (got_q.size() != exp_q.size())
      chk(0, tag, "beat count", got_q.size(), exp_q.size());
    else if (bad_i >= 0)
      chk(0, tag, "beat {last,data}", int'(got_q[bad_i]), int'(exp_q[bad_i]));
    else
      chk(1, tag, "beats", 0, 0);
    chk(ch == eh, "R9", {tag, " err_hdr pulses"}, ch, eh);
    chk(cl == el, "R9", {tag, " err_len pulses"}, cl, el);
    chk(cx == ex, "R9", {tag, " err_xfer pulses"}, cx, ex);
    xb.delete();
  endtask

  task automatic run_x(string tag);
    prep(); send(); finish_x(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(m_tvalid == 1'b0, "R10", "m_tvalid in reset", int'(m_tvalid), 0);
    chk(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
    chk({e_hdr, e_len, e_xfer} == 3'b0, "R10", "errors in reset", int'({e_hdr, e_len, e_xfer}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1 && m_tvalid == 1'b0, "R10", "idle after reset", int'({in_ready, m_tvalid}), 2);

    // R4/R3/R5: every length around the limit, followed by an odd frame
    for (int l = 0; l <= 22; l++) begin
      put_frame(l, 1'b1); put_frame(3, 1'b1);
      run_x(l > 20 ? "R3" : "R4");
    end
    // R5/R6: single odd frames, with and without pad
    for (int l = 1; l <= 9; l++) begin put_frame(l, 1'b1); run_x("R5"); end
    for (int l = 1; l <= 9; l += 2) begin put_frame(l, 1'b0); run_x("R6"); end
    // R2: corrupted complement, trailing frame must be dropped
    for (int l = 0; l <= 10; l++) begin
      put_hdr(l, 1'b1, 1'b0);
      for (int i = 0; i < l; i++) xb.push_back(pay(l, i));
      put_frame(2, 1'b1);
      run_x("R2");
    end
    // R7: truncation at every payload position
    for (int l = 2; l <= 8; l++)
      for (int k = 1; k < l; k++) begin
        put_hdr(l, 1'b0, 1'b0);
        for (int i = 0; i < k; i++) xb.push_back(pay(l, i));
        run_x("R7");
      end
    // R6: short tails and bare header at the end
    put_frame(2, 1'b1); xb.push_back(8'h11); xb.push_back(8'h22); run_x("R6");
    put_frame(2, 1'b1); put_hdr(0, 1'b0, 1'b0); run_x("R6");
    put_frame(4, 1'b1); put_hdr(6, 1'b0, 1'b0); run_x("R6");
    xb.push_back(8'h00); run_x("R6");
    // R1: ignored header bits set
    for (int l = 1; l <= 6; l++) begin put_hdr(l, 1'b0, 1'b1);
      for (int i = 0; i < l; i++) xb.push_back(pay(l, i));
      if (l % 2 == 1) xb.push_back(8'h5A);
      put_frame(1, 1'b1);
      run_x("R1");
    end
    // R8: random packs under random gaps and backpressure
    bp = 1; gaps = 1;
    for (int t = 0; t < 25; t++) begin
      for (int f = 0; f < 4; f++) put_frame($urandom_range(0, 20), 1'b1);
      run_x("R8");
    end
    // R8: directed stall mid-payload
    bp = 0; gaps = 0;
    put_frame(5, 1'b1); put_frame(2, 1'b1);
    prep();
    hold = 1;
    fork
      send();
      begin
        repeat (30) @(negedge clk);
        chk(in_ready == 1'b0, "R8", "in_ready during stall", int'(in_ready), 0);
        chk(m_tvalid == 1'b1 && m_tdata == pay(5, 0), "R8", "held beat",
            int'({m_tvalid, m_tdata}), int'({1'b1, pay(5, 0)}));
        hold = 0;
      end
    join
    finish_x("R8");
    // R3/R4: full-size frames at the usual limit
    max_len = 11'd1518; bp = 1;
    put_frame(1518, 1'b1); run_x("R4");
    put_frame(1519, 1'b1); run_x("R3");
    summary();
    $finish;
  end
endmodule